// File: doc/BRIEF.md
# SPI Flash Boot Image Loader

This block is a hardware boot sequencer. After a start pulse it reads an executable image out of an SPI NOR flash and copies it into an instruction memory organised as 16-bit words. The image opens with a three-word header: a signature word, the payload length in bytes and an expected checksum. The loader checks the signature and the length, copies the payload words from memory word 0 upward, writes zeros into every word the payload leaves unused, and then compares an XOR checksum of the payload against the header value. The result is reported on a done flag, or on an error flag with an 8-bit code.

The loader fetches every flash byte with its own complete read transaction. It talks to a byte-wide SPI serializer through a request/acknowledge handshake and holds the chip select low only for the length of one transaction. A strap input marks the memory as read-only. In that case the load is refused before any flash traffic starts. Done and error are final: they hold until reset, and a load runs at most once per reset.

Top module: `flash_image_loader`

## Requirements
- R1: When `start` is seen while `mem_ro` is high, `error` rises with `err_code` 0x01. No SPI transaction starts and no memory word is written.
- R2: Each flash byte is read in one transaction framed by `spi_cs_n` low. The transaction exchanges exactly five bytes in this order: command 0x03, address bits 23:16, address bits 15:8, address bits 7:0, then a dummy byte. The byte received during the fifth exchange is the data. `spi_cs_n` returns high between transactions.
- R3: The image header begins at flash address `BASE_ADDR` (default 0x040000). Word k occupies flash bytes `BASE_ADDR`+2k and +2k+1. The byte at the lower address is the upper half of the word.
- R4: If header word 0 is not 0xCAFE, `error` rises with code 0x02 after exactly two byte transactions, and no memory word is written.
- R5: If header word 1 (size in bytes) is greater than 2*`MEM_WORDS`, `error` rises with code 0x04 after exactly four byte transactions, and no memory word is written. A size equal to 2*`MEM_WORDS` is accepted.
- R6: Payload word j is read from header offset 6+2j and is written to memory word j, for j from 0 to floor(size/2)-1. Each such memory word is written exactly once.
- R7: Every memory word from floor(size/2) to `MEM_WORDS`-1 is written once with 0x0000.
- R8: After the fill, the XOR of all payload words (starting from 0x0000) is compared with header word 2. If they match, `done` rises and `err_code` stays 0x00. If they differ, `error` rises with code 0x08.
- R9: Once `done` or `error` is high, it stays high with `err_code` unchanged until reset. From then on no memory write and no SPI transaction occurs, even if `start` is pulsed again.
- R10: `spi_req` stays high with `spi_tx` unchanged until `spi_ack` is seen. One byte is exchanged per acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (taken only while idle) |
| mem_ro | input | 1 | Strap: instruction memory is read-only |
| spi_req | output | 1 | Byte exchange request to the SPI serializer |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | One-cycle pulse: exchange complete, `spi_rx` valid |
| spi_rx | input | 8 | Byte shifted in |
| spi_cs_n | output | 1 | Flash chip select, active low |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | $clog2(MEM_WORDS) | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| done | output | 1 | Image loaded and checked |
| error | output | 1 | Load aborted |
| err_code | output | 8 | 0x00 none, 0x01 read-only, 0x02 signature, 0x04 size, 0x08 checksum |

## Verification
The assertions rely on the serializer pulsing `spi_ack` for a single cycle, and only while `spi_req` is high. The bench's flash model keeps to this: it drops the acknowledge on the following cycle and inserts zero to two wait cycles before each one. The assertions also rely on `start` having no meaning after the load has finished. The bench pulses `start` again at that point on purpose, to show that nothing happens. Every image length from 0 to 2*`MEM_WORDS` bytes is swept on a 16-word configuration, together with odd lengths, lengths that are too large, a bad signature, a corrupted checksum and the read-only strap.

// File: rtl/fil_pkg.sv
package fil_pkg;

    localparam logic [15:0] IMG_SIGNATURE = 16'hCAFE;
    localparam logic [7:0]  FLASH_RD_CMD  = 8'h03;
    localparam int          FRAME_BYTES   = 5;

    typedef enum logic [7:0] {
        ERR_NONE  = 8'h00,
        ERR_RO    = 8'h01,
        ERR_SIG   = 8'h02,
        ERR_SIZE  = 8'h04,
        ERR_CKSUM = 8'h08
    } load_err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_EVAL,
        S_FILL,
        S_CHECK,
        S_DONE,
        S_ERR
    } seq_state_e;

    // Byte sent at position pos of a single-byte read frame.
    function automatic logic [7:0] frame_byte(input logic [23:0] a, input logic [2:0] pos);
        logic [7:0] b;
        case (pos)
            3'd0:    b = FLASH_RD_CMD;
            3'd1:    b = a[23:16];
            3'd2:    b = a[15:8];
            3'd3:    b = a[7:0];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fil_byte_reader.sv
module fil_byte_reader
    import fil_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic [23:0] addr,
    output logic        spi_req,
    output logic [7:0]  spi_tx,
    input  logic        spi_ack,
    input  logic [7:0]  spi_rx,
    output logic        spi_cs_n,
    output logic        done,
    output logic [7:0]  data
);
    localparam logic [2:0] LAST_POS = 3'(FRAME_BYTES - 1);

    logic        busy;
    logic [2:0]  pos;
    logic [23:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            pos      <= '0;
            addr_q   <= '0;
            spi_req  <= 1'b0;
            spi_tx   <= '0;
            spi_cs_n <= 1'b1;
            done     <= 1'b0;
            data     <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy     <= 1'b1;
                    pos      <= '0;
                    addr_q   <= addr;
                    spi_cs_n <= 1'b0;
                    spi_req  <= 1'b1;
                    spi_tx   <= frame_byte(addr, 3'd0);
                end
            end else if (spi_ack) begin
                if (pos == LAST_POS) begin
                    data     <= spi_rx;
                    busy     <= 1'b0;
                    spi_req  <= 1'b0;
                    spi_cs_n <= 1'b1;
                    spi_tx   <= '0;
                    done     <= 1'b1;
                end else begin
                    pos    <= pos + 3'd1;
                    spi_tx <= frame_byte(addr_q, pos + 3'd1);
                end
            end
        end
    end

endmodule

// File: rtl/fil_sequencer.sv
module fil_sequencer
    import fil_pkg::*;
#(
    parameter int          MEM_WORDS = 64,
    parameter logic [23:0] BASE_ADDR = 24'h040000,
    parameter int          AW        = $clog2(MEM_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mem_ro,
    output logic          rd_go,
    output logic [23:0]   rd_addr,
    input  logic          rd_done,
    input  logic [7:0]    rd_byte,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          done,
    output logic          error,
    output logic [7:0]    err_code
);
    localparam int          CW        = AW + 2;
    localparam logic [16:0] MEM_BYTES = 17'(2 * MEM_WORDS);
    localparam logic [AW:0] NW_MAX    = (AW + 1)'(MEM_WORDS);
    localparam logic [AW-1:0] LAST_W  = AW'(MEM_WORDS - 1);

    seq_state_e    state;
    logic [CW-1:0] widx;
    logic          lo_phase;
    logic [7:0]    hi_byte;
    logic [15:0]   word;
    logic [AW:0]   nwords;
    logic [15:0]   expect_ck;
    logic [15:0]   cksum;
    logic [AW-1:0] faddr;

    assign rd_go   = (state == S_ISSUE);
    assign rd_addr = BASE_ADDR + 24'({widx, lo_phase});

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            widx      <= '0;
            lo_phase  <= 1'b0;
            hi_byte   <= '0;
            word      <= '0;
            nwords    <= '0;
            expect_ck <= '0;
            cksum     <= '0;
            faddr     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            error     <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            mem_we <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        if (mem_ro) begin
                            state    <= S_ERR;
                            error    <= 1'b1;
                            err_code <= ERR_RO;
                        end else begin
                            state <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: begin
                    if (rd_done) begin
                        if (!lo_phase) begin
                            hi_byte  <= rd_byte;
                            lo_phase <= 1'b1;
                            state    <= S_ISSUE;
                        end else begin
                            word     <= {hi_byte, rd_byte};
                            lo_phase <= 1'b0;
                            state    <= S_EVAL;
                        end
                    end
                end
                S_EVAL: begin
                    if (widx == CW'(0)) begin
                        if (word != IMG_SIGNATURE) begin
                            state    <= S_ERR;
                            error    <= 1'b1;
                            err_code <= ERR_SIG;
                        end else begin
                            widx  <= widx + CW'(1);
                            state <= S_ISSUE;
                        end
                    end else if (widx == CW'(1)) begin
                        if ({1'b0, word} > MEM_BYTES) begin
                            state    <= S_ERR;
                            error    <= 1'b1;
                            err_code <= ERR_SIZE;
                        end else begin
                            nwords <= word[AW+1:1];
                            widx   <= widx + CW'(1);
                            state  <= S_ISSUE;
                        end
                    end else if (widx == CW'(2)) begin
                        expect_ck <= word;
                        widx      <= widx + CW'(1);
                        if (nwords == '0) begin
                            faddr <= '0;
                            state <= S_FILL;
                        end else begin
                            state <= S_ISSUE;
                        end
                    end else begin
                        mem_we    <= 1'b1;
                        mem_addr  <= AW'(widx - CW'(3));
                        mem_wdata <= word;
                        cksum     <= cksum ^ word;
                        widx      <= widx + CW'(1);
                        if ((widx - CW'(2)) == CW'(nwords)) begin
                            if (nwords == NW_MAX) begin
                                state <= S_CHECK;
                            end else begin
                                faddr <= AW'(nwords);
                                state <= S_FILL;
                            end
                        end else begin
                            state <= S_ISSUE;
                        end
                    end
                end
                S_FILL: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= faddr;
                    mem_wdata <= 16'h0000;
                    if (faddr == LAST_W) begin
                        state <= S_CHECK;
                    end else begin
                        faddr <= faddr + AW'(1);
                    end
                end
                S_CHECK: begin
                    if (cksum == expect_ck) begin
                        state <= S_DONE;
                        done  <= 1'b1;
                    end else begin
                        state    <= S_ERR;
                        error    <= 1'b1;
                        err_code <= ERR_CKSUM;
                    end
                end
                S_DONE: state <= S_DONE;
                S_ERR:  state <= S_ERR;
                default: state <= S_ERR;
            endcase
        end
    end

endmodule

// File: rtl/flash_image_loader.sv
module flash_image_loader
    import fil_pkg::*;
#(
    parameter int          MEM_WORDS = 64,
    parameter logic [23:0] BASE_ADDR = 24'h040000,
    localparam int         AW        = $clog2(MEM_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mem_ro,
    output logic          spi_req,
    output logic [7:0]    spi_tx,
    input  logic          spi_ack,
    input  logic [7:0]    spi_rx,
    output logic          spi_cs_n,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          done,
    output logic          error,
    output logic [7:0]    err_code
);
    logic        rd_go;
    logic [23:0] rd_addr;
    logic        rd_done;
    logic [7:0]  rd_byte;

    fil_sequencer #(
        .MEM_WORDS (MEM_WORDS),
        .BASE_ADDR (BASE_ADDR),
        .AW        (AW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_ro    (mem_ro),
        .rd_go     (rd_go),
        .rd_addr   (rd_addr),
        .rd_done   (rd_done),
        .rd_byte   (rd_byte),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done),
        .error     (error),
        .err_code  (err_code)
    );

    fil_byte_reader u_rd (
        .clk      (clk),
        .rst      (rst),
        .go       (rd_go),
        .addr     (rd_addr),
        .spi_req  (spi_req),
        .spi_tx   (spi_tx),
        .spi_ack  (spi_ack),
        .spi_rx   (spi_rx),
        .spi_cs_n (spi_cs_n),
        .done     (rd_done),
        .data     (rd_byte)
    );

endmodule

// File: rtl/fil_checker.sv
module fil_checker #(
    parameter int MEM_WORDS = 64,
    parameter int AW        = $clog2(MEM_WORDS)
) (
    input logic          clk,
    input logic          rst,
    input logic          spi_req,
    input logic [7:0]    spi_tx,
    input logic          spi_ack,
    input logic          spi_cs_n,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          error,
    input logic [7:0]    err_code
);
    // R2: a byte is only requested inside a selected frame
    p_req_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        spi_req |-> !spi_cs_n);

    // R10: request and byte stay put until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

    // R9: error is final with a frozen code
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        error |=> (error && $stable(err_code)));

    // R9: done is final
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R9: nothing is written once the load has ended
    p_quiet_after_end_r9: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !mem_we);

    // R9: no new frame once the load has ended
    p_no_frame_after_end_r9: assert property (@(posedge clk) disable iff (rst)
        ((done || error) && spi_cs_n) |=> spi_cs_n);

    // R7: writes stay inside the memory
    p_addr_range_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (32'(mem_addr) < MEM_WORDS));

    // R8: the two outcomes exclude each other
    p_outcome_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

endmodule

bind flash_image_loader fil_checker #(.MEM_WORDS(MEM_WORDS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .spi_req  (spi_req),
    .spi_tx   (spi_tx),
    .spi_ack  (spi_ack),
    .spi_cs_n (spi_cs_n),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done),
    .error    (error),
    .err_code (err_code)
);

// File: tb/flash_image_loader_tb.sv
module flash_image_loader_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          NW         = 16;
    localparam int          AW         = $clog2(NW);
    localparam logic [23:0] BASE       = 24'h040000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mem_ro = 1'b0;
    logic          spi_req;
    logic [7:0]    spi_tx;
    logic          spi_ack = 1'b0;
    logic [7:0]    spi_rx = 8'h00;
    logic          spi_cs_n;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          done;
    logic          error;
    logic [7:0]    err_code;

    flash_image_loader #(.MEM_WORDS(NW), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mem_ro(mem_ro),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
        .spi_cs_n(spi_cs_n), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done), .error(error), .err_code(err_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // image description
    logic [15:0] img_sig;
    logic [15:0] img_size;
    logic [15:0] img_ck;

    // observed memory and bus activity
    logic [15:0] mem_model [NW];
    int          wr_cnt [NW];
    int          total_wr;
    int          txn;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] payload(input int i);
        return 16'(i * 16'h3B1D) ^ 16'hA5C3;
    endfunction

    function automatic logic [7:0] img_byte(input int off);
        int w;
        logic [15:0] v;
        w = off / 2;
        if (w == 0)      v = img_sig;
        else if (w == 1) v = img_size;
        else if (w == 2) v = img_ck;
        else             v = payload(w - 3);
        return (off % 2 == 0) ? v[15:8] : v[7:0];
    endfunction

    // flash model and memory observer, acting on falling edges
    initial begin
        int bi;
        int dly;
        logic cs_prev;
        logic [23:0] aacc;
        bi = 0; dly = 0; cs_prev = 1'b1; aacc = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                spi_ack = 1'b0; bi = 0; dly = 0; cs_prev = 1'b1;
            end else begin
                if (mem_we) begin
                    total_wr++;
                    mem_model[mem_addr] = mem_wdata;
                    wr_cnt[mem_addr]++;
                end
                if (!cs_prev && spi_cs_n) begin
                    txn++;
                    // R2: five exchanges per frame
                    check(bi == 5, "R2 frame length", bi, 5);
                end
                if (spi_cs_n) bi = 0;
                cs_prev = spi_cs_n;
                if (spi_ack) begin
                    spi_ack = 1'b0;
                end else if (spi_req) begin
                    if (dly < (txn % 3)) begin
                        dly++;
                    end else begin
                        dly = 0;
                        case (bi)
                            0: check(spi_tx == 8'h03, "R2 read command", spi_tx, 8'h03);
                            1: aacc[23:16] = spi_tx;
                            2: aacc[15:8]  = spi_tx;
                            3: aacc[7:0]   = spi_tx;
                            default: ;
                        endcase
                        if (bi == 4) begin
                            // R3: fetch stays at or above the image base
                            if (aacc < BASE) check(1'b0, "R3 address", aacc, BASE);
                            spi_rx = img_byte(int'(aacc - BASE));
                        end else begin
                            spi_rx = 8'hEE;
                        end
                        bi++;
                        spi_ack = 1'b1;
                    end
                end
            end
        end
    end

    task automatic run_case(input logic [15:0] sig, input logic [15:0] size,
                            input bit corrupt, input bit ro, input logic [7:0] exp_code);
        int nw;
        int exp_txn;
        int exp_wr;
        int wr_before;
        int txn_before;
        bit ok;
        logic [15:0] x;
        img_sig  = sig;
        img_size = size;
        nw = int'(size) / 2;
        x = 16'h0000;
        for (int i = 0; i < nw && i < NW; i++) x = x ^ payload(i);
        img_ck = corrupt ? (x ^ 16'h0100) : x;

        rst = 1'b1;
        start = 1'b0;
        mem_ro = ro;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NW; i++) begin
            mem_model[i] = 16'hDEAD;
            wr_cnt[i] = 0;
        end
        total_wr = 0;
        txn = 0;
        rst = 1'b0;
        @(negedge clk);
        check(!done && !error && err_code == 8'h00 && spi_cs_n && !spi_req && !mem_we,
              "R9 reset state", {done, error, spi_cs_n, spi_req, mem_we}, 5'b00100);

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ok = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            if (done || error) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check(ok, "R8 load finishes", ok, 1);

        if (exp_code == 8'h00) begin
            check(done && !error && err_code == 8'h00, "R8 done result",
                  {done, error, err_code}, 10'h200);
        end else begin
            check(error && !done && err_code == exp_code, "R1 R4 R5 R8 error code",
                  err_code, exp_code);
        end

        if (exp_code == 8'h01)      begin exp_txn = 0; exp_wr = 0; end
        else if (exp_code == 8'h02) begin exp_txn = 2; exp_wr = 0; end
        else if (exp_code == 8'h04) begin exp_txn = 4; exp_wr = 0; end
        else                        begin exp_txn = 6 + 2 * nw; exp_wr = NW; end
        check(txn == exp_txn, "R2 R4 R5 transaction count", txn, exp_txn);
        check(total_wr == exp_wr, "R1 R6 R7 write count", total_wr, exp_wr);

        if (exp_wr != 0) begin
            for (int i = 0; i < NW; i++) begin
                logic [15:0] e;
                e = (i < nw) ? payload(i) : 16'h0000;
                if (i < nw) check(mem_model[i] == e, "R6 payload word", mem_model[i], e);
                else        check(mem_model[i] == e, "R7 zero fill", mem_model[i], e);
                check(wr_cnt[i] == 1, "R6 R7 single write", wr_cnt[i], 1);
            end
        end

        // R9: a second start after the end changes nothing
        wr_before = total_wr;
        txn_before = txn;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        check(total_wr == wr_before && txn == txn_before && spi_cs_n,
              "R9 quiet after end", total_wr + txn, wr_before + txn_before);
        check((exp_code == 8'h00) ? (done && !error) : (error && err_code == exp_code),
              "R9 result held", err_code, exp_code);
    endtask

    initial begin
        // R6 R7 R8: every even size including zero and full memory
        for (int s = 0; s <= 2 * NW; s += 2) run_case(16'hCAFE, 16'(s), 1'b0, 1'b0, 8'h00);
        // R6: odd sizes round down
        run_case(16'hCAFE, 16'd7, 1'b0, 1'b0, 8'h00);
        run_case(16'hCAFE, 16'(2 * NW + 1), 1'b0, 1'b0, 8'h04);
        // R5: too large
        run_case(16'hCAFE, 16'(2 * NW + 2), 1'b0, 1'b0, 8'h04);
        run_case(16'hCAFE, 16'hFFFF, 1'b0, 1'b0, 8'h04);
        // R4: wrong signatures
        run_case(16'hCAFF, 16'd4, 1'b0, 1'b0, 8'h02);
        run_case(16'hFECA, 16'd4, 1'b0, 1'b0, 8'h02);
        // R8: checksum mismatch, still fills
        run_case(16'hCAFE, 16'd10, 1'b1, 1'b0, 8'h08);
        run_case(16'hCAFE, 16'd0, 1'b1, 1'b0, 8'h08);
        // R1: read-only strap
        run_case(16'hCAFE, 16'd8, 1'b0, 1'b1, 8'h01);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule